// File: doc/BRIEF.md
# Serial Flash Instruction Sequencer

This block is the engine of a serial flash host. It holds a table of short instruction programs and runs one of them against a single external device. Each run drives chip select low, toggles a serial clock and moves bits over one, two, four or eight data lanes. The phases of a transfer (opcode byte, address, idle cycles, data) are not fixed. They come one by one from the stored instruction words, so the same hardware can issue a status poll, a quad page program or an octal fast read.

Software or a boot loader fills the table through a simple write port. A single-cycle start pulse then picks a sequence and supplies the address and the data byte count for that run. Bytes to be written are pulled from a valid/ready byte stream. Bytes that are read leave as one-cycle pulses on a byte output. The block reports when it is idle, and it raises a sticky error flag when a program holds an instruction it cannot execute.

Each serial clock beat takes two core clock cycles: one cycle low and one cycle high. Outputs change only while the clock is low. The device is expected to sample on the rising edge, and the block samples incoming lanes during the high cycle.

Top module: `lut_flash_seq`

## Requirements
- R1: After reset, and whenever a sequence has ended, idle is 1, csN is 1, sck is 0, laneOe is 0 and rxValid is 0.
- R2: Table word 4*s+w (s = sequence 0..31, w = 0..3) belongs to sequence s. Each word holds two 16-bit instructions, and the one in bits [15:0] runs before the one in bits [31:16]. Every instruction splits into opcode [15:10], lane code [9:8] and operand [7:0]. A run starts at the low instruction of word 0 of the selected sequence.
- R3: Lane code 0, 1, 2 or 3 gives N = 1, 2, 4 or 8 active lanes, using lanes 0..N-1. Each beat carries N bits, and the stream is sent most significant bit first, so lane 0 holds the last bit of each group. Active lanes show laneOe = 1 only while that beat is driven. Every other lane stays released.
- R4: Opcode 0x01 shifts out its operand as one byte.
- R5: Opcode 0x02 shifts out the low K bits of startAddr, most significant first, where K is the operand (8, 16, 24 or 32).
- R6: Opcode 0x0C produces operand beats (0 to 64) with all lanes released. An operand of 0 produces no beats.
- R7: Opcode 0x08 sends byteCount bytes, each taken from txData when txValid and txReady are both 1. While no byte is offered, sck stays low and no beat occurs.
- R8: Opcode 0x09 collects byteCount bytes from laneIn, sampled once per beat while sck is high. Each byte appears on rxData together with a single-cycle rxValid pulse.
- R9: A write or read data instruction with byteCount 0 produces no beats and lets the sequence go on.
- R10: Opcode 0x00, or completing the eighth instruction, ends the run. Instructions after a stop are not executed.
- R11: An opcode outside the six above, an address operand other than 8, 16, 24 or 32, or a dummy operand above 64 ends the run with no beat for that instruction and sets err. err stays set until the next accepted start clears it.
- R12: A start is accepted only while idle. One cycle after an accepted start, idle is 0 and csN is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tblWrEn | input | 1 | Table write strobe |
| tblWrAddr | input | 7 | Table word index, 4*sequence + word |
| tblWrData | input | 32 | Table word value |
| start | input | 1 | Start pulse, accepted while idle |
| seqIdx | input | 5 | Sequence to run |
| startAddr | input | 32 | Address used by address instructions |
| byteCount | input | 16 | Data bytes for the data instruction |
| txData | input | 8 | Outgoing byte |
| txValid | input | 1 | Outgoing byte available |
| txReady | output | 1 | Block takes txData this cycle |
| rxData | output | 8 | Incoming byte |
| rxValid | output | 1 | rxData valid for one cycle |
| laneIn | input | 8 | Data lanes from device |
| laneOut | output | 8 | Data lanes to device |
| laneOe | output | 8 | Per-lane output enable |
| sck | output | 1 | Serial clock |
| csN | output | 1 | Active-low chip select |
| idle | output | 1 | No sequence running |
| err | output | 1 | Sticky unsupported-instruction flag |

## Verification
The hardest case to reach from the ports is a write data stream that runs dry in the middle of a sequence. In that case the serial clock must freeze between bytes without losing its beat alignment. The bench stalls its byte source once the first byte has been taken and counts clock beats across the stall window. Read data has a similar difficulty: it must line up with a beat count that depends on every earlier phase. The bench's device model counts falling clock edges, presents each data group only after the computed number of command, address and dummy beats, and changes its lanes only after the block has sampled them.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
  localparam int WORD_W = 32;
  localparam int INSTR_W = 16;
  localparam int SLOTS = 8;

  localparam logic [5:0] OP_STOP  = 6'h00;
  localparam logic [5:0] OP_CMD   = 6'h01;
  localparam logic [5:0] OP_ADDR  = 6'h02;
  localparam logic [5:0] OP_WRITE = 6'h08;
  localparam logic [5:0] OP_READ  = 6'h09;
  localparam logic [5:0] OP_DUMMY = 6'h0C;

  typedef enum logic [2:0] {K_CMD, K_ADDR, K_DUMMY, K_WR, K_RD} kind_e;
  typedef enum logic [1:0] {LD_OPR, LD_ADDR, LD_TX} ldsel_e;
  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_WAITTX, ST_LOW, ST_HIGH} state_e;

  typedef struct packed {
    logic       latchAddr;
    logic       load;
    ldsel_e     loadSel;
    logic [7:0] operand;
    logic       shift;
    logic       capture;
    logic       lastBeat;
    logic       drive;
    logic [1:0] pad;
  } strobe_t;
endpackage

// File: rtl/lfs_table.sv
module lfs_table #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [AW-1:0]    rdAddr,
  output logic [WIDTH-1:0] rdData
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  assign rdData = mem[rdAddr];
endmodule

// File: rtl/lfs_control.sv
module lfs_control
  import lfs_pkg::*;
#(
  parameter int SEQ_W = 5,
  parameter int CNT_W = 16,
  parameter int ADDR_W = 32,
  parameter int DUMMY_MAX = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [SEQ_W-1:0]  seqIdx,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [WORD_W-1:0] word,
  input  logic              txValid,
  output logic [SEQ_W+1:0]  wordAddr,
  output strobe_t           strb,
  output logic              txReady,
  output logic              sck,
  output logic              csN,
  output logic              idle,
  output logic              err
);
  localparam int SLOT_W = $clog2(SLOTS);

  state_e            state;
  kind_e             kind;
  logic [SEQ_W-1:0]  seqR;
  logic [SLOT_W-1:0] slot;
  logic [CNT_W-1:0]  bytesLeft;
  logic [6:0]        beats;
  logic [1:0]        padR;

  logic [INSTR_W-1:0] instr;
  logic [5:0]         opc;
  logic [1:0]         ipad;
  logic [7:0]         opr;
  logic               addrOk, dummyBad, driving, lastSlot;
  state_e             advState;

  assign wordAddr = {seqR, slot[SLOT_W-1:1]};
  assign instr    = slot[0] ? word[WORD_W-1:INSTR_W] : word[INSTR_W-1:0];
  assign opc      = instr[15:10];
  assign ipad     = instr[9:8];
  assign opr      = instr[7:0];
  assign addrOk   = (opr == 8'd8 || opr == 8'd16 || opr == 8'd24 || opr == 8'd32)
                    && (int'(opr) <= ADDR_W);
  assign dummyBad = int'(opr) > DUMMY_MAX;
  assign lastSlot = (slot == SLOT_W'(SLOTS - 1));
  assign advState = lastSlot ? ST_IDLE : ST_FETCH;
  assign driving  = (kind == K_CMD) || (kind == K_ADDR) || (kind == K_WR);

  assign sck  = (state == ST_HIGH);
  assign csN  = (state == ST_IDLE);
  assign idle = (state == ST_IDLE);

  always_comb begin
    strb         = '0;
    strb.loadSel = LD_OPR;
    strb.operand = opr;
    strb.pad     = padR;
    txReady      = 1'b0;
    case (state)
      ST_IDLE:  strb.latchAddr = start;
      ST_FETCH: begin
        if (opc == OP_CMD) strb.load = 1'b1;
        if (opc == OP_ADDR && addrOk) begin
          strb.load    = 1'b1;
          strb.loadSel = LD_ADDR;
        end
      end
      ST_WAITTX: begin
        txReady      = 1'b1;
        strb.load    = txValid;
        strb.loadSel = LD_TX;
      end
      ST_LOW:   strb.drive = driving;
      ST_HIGH: begin
        strb.drive    = driving;
        strb.shift    = 1'b1;
        strb.capture  = (kind == K_RD);
        strb.lastBeat = (kind == K_RD) && (beats == 7'd1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      kind      <= K_CMD;
      seqR      <= '0;
      slot      <= '0;
      bytesLeft <= '0;
      beats     <= '0;
      padR      <= '0;
      err       <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          seqR      <= seqIdx;
          slot      <= '0;
          bytesLeft <= byteCount;
          err       <= 1'b0;
          state     <= ST_FETCH;
        end
        ST_FETCH: begin
          padR <= ipad;
          case (opc)
            OP_STOP: state <= ST_IDLE;
            OP_CMD: begin
              kind  <= K_CMD;
              beats <= 7'd8 >> ipad;
              state <= ST_LOW;
            end
            OP_ADDR: begin
              if (addrOk) begin
                kind  <= K_ADDR;
                beats <= 7'(opr >> ipad);
                state <= ST_LOW;
              end else begin
                err   <= 1'b1;
                state <= ST_IDLE;
              end
            end
            OP_DUMMY: begin
              if (dummyBad) begin
                err   <= 1'b1;
                state <= ST_IDLE;
              end else if (opr == 8'd0) begin
                slot  <= slot + 1'b1;
                state <= advState;
              end else begin
                kind  <= K_DUMMY;
                beats <= 7'(opr);
                state <= ST_LOW;
              end
            end
            OP_WRITE, OP_READ: begin
              if (bytesLeft == '0) begin
                slot  <= slot + 1'b1;
                state <= advState;
              end else if (opc == OP_WRITE) begin
                kind  <= K_WR;
                state <= ST_WAITTX;
              end else begin
                kind  <= K_RD;
                beats <= 7'd8 >> ipad;
                state <= ST_LOW;
              end
            end
            default: begin
              err   <= 1'b1;
              state <= ST_IDLE;
            end
          endcase
        end
        ST_WAITTX: if (txValid) begin
          beats <= 7'd8 >> padR;
          state <= ST_LOW;
        end
        ST_LOW: state <= ST_HIGH;
        ST_HIGH: begin
          beats <= beats - 1'b1;
          if (beats != 7'd1) begin
            state <= ST_LOW;
          end else if ((kind == K_WR || kind == K_RD) && bytesLeft != CNT_W'(1)) begin
            bytesLeft <= bytesLeft - 1'b1;
            beats     <= 7'd8 >> padR;
            state     <= (kind == K_WR) ? ST_WAITTX : ST_LOW;
          end else begin
            if (kind == K_WR || kind == K_RD) bytesLeft <= '0;
            slot  <= slot + 1'b1;
            state <= advState;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lfs_datapath.sv
module lfs_datapath
  import lfs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [7:0]        txData,
  input  logic [LANES-1:0]  laneIn,
  output logic [LANES-1:0]  laneOut,
  output logic [LANES-1:0]  laneOe,
  output logic [7:0]        rxData,
  output logic              rxValid
);
  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] sr;
  logic [7:0]        rxSr, nextRx, inMask;
  int                laneCnt;

  assign laneCnt = 1 << strb.pad;
  assign inMask  = 8'((9'd1 << laneCnt) - 9'd1);
  assign nextRx  = 8'(rxSr << laneCnt) | (laneIn[7:0] & inMask);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign laneOe[k]  = strb.drive && (k < laneCnt);
    assign laneOut[k] = (strb.drive && (k < laneCnt)) ? sr[ADDR_W - laneCnt + k] : 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      sr      <= '0;
      rxSr    <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (strb.latchAddr) addrReg <= startAddr;
      if (strb.load) begin
        case (strb.loadSel)
          LD_ADDR: sr <= addrReg << (ADDR_W - int'(strb.operand));
          LD_TX:   sr <= {txData, {(ADDR_W-8){1'b0}}};
          default: sr <= {strb.operand, {(ADDR_W-8){1'b0}}};
        endcase
      end else if (strb.shift) begin
        sr <= sr << laneCnt;
      end
      if (strb.capture) begin
        rxSr <= nextRx;
        if (strb.lastBeat) begin
          rxData  <= nextRx;
          rxValid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lut_flash_seq.sv
module lut_flash_seq
  import lfs_pkg::*;
#(
  parameter int NUM_SEQ = 32,
  parameter int CNT_W = 16,
  parameter int ADDR_W = 32,
  localparam int SEQ_W = $clog2(NUM_SEQ),
  localparam int TBL_DEPTH = NUM_SEQ * (SLOTS / 2),
  localparam int TBL_AW = $clog2(TBL_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tblWrEn,
  input  logic [TBL_AW-1:0] tblWrAddr,
  input  logic [WORD_W-1:0] tblWrData,
  input  logic              start,
  input  logic [SEQ_W-1:0]  seqIdx,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [7:0]        txData,
  input  logic              txValid,
  output logic              txReady,
  output logic [7:0]        rxData,
  output logic              rxValid,
  input  logic [7:0]        laneIn,
  output logic [7:0]        laneOut,
  output logic [7:0]        laneOe,
  output logic              sck,
  output logic              csN,
  output logic              idle,
  output logic              err
);
  strobe_t           strb;
  logic [TBL_AW-1:0] wordAddr;
  logic [WORD_W-1:0] word;

  lfs_table #(.DEPTH(TBL_DEPTH), .WIDTH(WORD_W)) table_i (
    .clk(clk), .wrEn(tblWrEn), .wrAddr(tblWrAddr), .wrData(tblWrData),
    .rdAddr(wordAddr), .rdData(word)
  );

  lfs_control #(.SEQ_W(SEQ_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .seqIdx(seqIdx), .byteCount(byteCount),
    .word(word), .txValid(txValid), .wordAddr(wordAddr), .strb(strb),
    .txReady(txReady), .sck(sck), .csN(csN), .idle(idle), .err(err)
  );

  lfs_datapath #(.ADDR_W(ADDR_W), .LANES(8)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .startAddr(startAddr), .txData(txData),
    .laneIn(laneIn), .laneOut(laneOut), .laneOe(laneOe),
    .rxData(rxData), .rxValid(rxValid)
  );
endmodule

// File: rtl/lut_flash_seq_chk.sv
module lut_flash_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       txReady,
  input logic       rxValid,
  input logic [7:0] laneOe,
  input logic       sck,
  input logic       csN,
  input logic       idle,
  input logic       err
);
  // R1
  sck_cs_chk: assert property (@(posedge clk) disable iff (!rstN) csN |-> !sck);
  // R3
  lane_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    (laneOe == 8'h00 || laneOe == 8'h01 || laneOe == 8'h03 || laneOe == 8'h0F || laneOe == 8'hFF));
  // R3
  lane_cs_chk: assert property (@(posedge clk) disable iff (!rstN) (laneOe != 8'h00) |-> !csN);
  // R7
  tx_stall_chk: assert property (@(posedge clk) disable iff (!rstN) txReady |-> (!sck && laneOe == 8'h00));
  // R8
  rx_cs_chk: assert property (@(posedge clk) disable iff (!rstN) rxValid |-> !$past(csN));
  // R11
  err_rise_chk: assert property (@(posedge clk) disable iff (!rstN) $rose(err) |-> idle);
  // R12
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN) (idle && start) |=> (!idle && !csN && !err));
  // R3
  sck_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) $rose(sck) |=> $fell(sck));
endmodule

bind lut_flash_seq lut_flash_seq_chk chk_i (
  .clk(clk), .rstN(rstN), .start(start), .txReady(txReady), .rxValid(rxValid),
  .laneOe(laneOe), .sck(sck), .csN(csN), .idle(idle), .err(err)
);

// File: tb/lut_flash_seq_tb_top.sv
module lut_flash_seq_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tblWrEn = 1'b0;
  logic [6:0]  tblWrAddr = '0;
  logic [31:0] tblWrData = '0;
  logic        start = 1'b0;
  logic [4:0]  seqIdx = '0;
  logic [31:0] startAddr = '0;
  logic [15:0] byteCount = '0;
  logic [7:0]  txData = '0;
  logic        txValid = 1'b0;
  logic        txReady;
  logic [7:0]  rxData;
  logic        rxValid;
  logic [7:0]  laneIn;
  logic [7:0]  laneOut, laneOe;
  logic        sck, csN, idle, err;

  always #2.5 clk = ~clk;

  lut_flash_seq dut_i (.*);

  int nChk = 0, nFail = 0;
  int beats, zBeats, txBitN, devBeat, rxN, txN, txIdx;
  int rdPre = 1000, rdLanes = 1;
  logic [255:0] txBits;
  logic [7:0]   txBuf [16];
  logic [7:0]   rxGot [16];
  logic         txHold = 1'b0;
  logic         errAfterStart;

  task automatic check(string req, string what, logic [255:0] act, logic [255:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(int op, int pad, int opr);
    return {6'(op), 2'(pad), 8'(opr)};
  endfunction

  function automatic logic [7:0] rdByte(int j);
    return 8'hC3 ^ 8'(j * 29);
  endfunction

  function automatic logic [7:0] devDrive(int beat, int pre, int lanes);
    int d, bpb;
    logic [7:0] b;
    if (beat < pre) return 8'h00;
    d = beat - pre;
    bpb = 8 / lanes;
    b = rdByte(d / bpb);
    return 8'((b >> (8 - lanes * ((d % bpb) + 1))) & 8'((9'd1 << lanes) - 9'd1));
  endfunction

  assign laneIn = devDrive(devBeat, rdPre, rdLanes);

  always @(posedge sck) begin
    beats++;
    if (laneOe == 8'h00) zBeats++;
    else for (int k = 7; k >= 0; k--)
      if (laneOe[k]) begin
        txBits = {txBits[254:0], laneOut[k]};
        txBitN++;
      end
  end

  always @(negedge sck) devBeat++;

  always @(posedge clk) begin
    if (rxValid && rxN < 16) begin rxGot[rxN] = rxData; rxN++; end
    if (txValid && txReady) txIdx++;
  end

  always @(negedge clk) begin
    txValid = (txIdx < txN) && !txHold;
    txData  = txBuf[txIdx % 16];
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  task automatic putWord(int s, int w, logic [15:0] hi, logic [15:0] lo);
    @(negedge clk);
    tblWrEn = 1'b1; tblWrAddr = 7'(s * 4 + w); tblWrData = {hi, lo};
    @(negedge clk);
    tblWrEn = 1'b0;
  endtask

  task automatic runSeq(int s, logic [31:0] a, int n);
    int t = 0;
    beats = 0; zBeats = 0; txBitN = 0; txBits = '0; rxN = 0; devBeat = 0; txIdx = 0;
    @(negedge clk);
    seqIdx = 5'(s); startAddr = a; byteCount = 16'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    errAfterStart = err;
    while (!idle && t < 5000) begin @(negedge clk); t++; end
    check("R10", "run finished", 256'(t < 5000), 256'(1));
  endtask

  task automatic testReset();
    check("R1", "idle", 256'(idle), 256'(1));
    check("R1", "csN", 256'(csN), 256'(1));
    check("R1", "sck", 256'(sck), 256'(0));
    check("R1", "laneOe", 256'(laneOe), 256'(0));
    check("R1", "err", 256'(err), 256'(0));
    check("R1", "rxValid", 256'(rxValid), 256'(0));
  endtask

  task automatic testCmd();
    putWord(3, 0, ins(0, 0, 0), ins(1, 0, 8'h9F));
    txN = 0;
    runSeq(3, 32'h0, 0);
    check("R4", "cmd bits", txBits, 256'h9F);
    check("R4", "cmd bit count", 256'(txBitN), 256'(8));
    check("R3", "single lane beats", 256'(beats), 256'(8));
    check("R1", "csN after end", 256'(csN), 256'(1));
  endtask

  task automatic testWriteQuad();
    int b0, b1;
    putWord(5, 0, ins(2, 2, 24), ins(1, 0, 8'h32));
    putWord(5, 1, ins(0, 0, 0), ins(8, 2, 0));
    txBuf[0] = 8'h11; txBuf[1] = 8'h22; txBuf[2] = 8'h33; txN = 3;
    fork
      runSeq(5, 32'h12345678, 3);
      begin
        wait (txIdx == 1);
        txHold = 1'b1;
        repeat (8) @(negedge clk);
        b0 = beats;
        repeat (12) @(negedge clk);
        b1 = beats;
        txHold = 1'b0;
      end
    join
    check("R7", "beats before stall", 256'(b0), 256'(16));
    check("R7", "no beat during stall", 256'(b1), 256'(b0));
    check("R5", "quad write bits", txBits, 256'h32_345678_112233);
    check("R3", "quad write bit count", 256'(txBitN), 256'(56));
    check("R3", "quad write beats", 256'(beats), 256'(20));
    txN = 0;
    runSeq(5, 32'h12345678, 0);
    check("R9", "zero count beats", 256'(beats), 256'(14));
    check("R9", "zero count bits", txBits, 256'h32_345678);
  endtask

  task automatic testReadOctal();
    putWord(7, 0, ins(2, 3, 32), ins(1, 0, 8'hEB));
    putWord(7, 1, ins(9, 3, 0), ins(12, 3, 6));
    putWord(7, 2, 16'h0, 16'h0);
    rdPre = 18; rdLanes = 8; txN = 0;
    runSeq(7, 32'hA1B2C3D4, 4);
    check("R5", "octal addr bits", txBits, 256'hEB_A1B2C3D4);
    check("R6", "released beats", 256'(zBeats), 256'(10));
    check("R8", "octal total beats", 256'(beats), 256'(22));
    check("R8", "octal byte count", 256'(rxN), 256'(4));
    for (int j = 0; j < 4; j++) check("R8", "octal byte", 256'(rxGot[j]), 256'(rdByte(j)));
    putWord(8, 0, ins(2, 0, 16), ins(1, 0, 8'h3B));
    putWord(8, 1, ins(0, 0, 0), ins(9, 1, 0));
    rdPre = 24; rdLanes = 2;
    runSeq(8, 32'h0000BEEF, 2);
    check("R5", "16-bit addr bits", txBits, 256'h3B_BEEF);
    check("R8", "dual total beats", 256'(beats), 256'(32));
    check("R8", "dual byte count", 256'(rxN), 256'(2));
    for (int j = 0; j < 2; j++) check("R8", "dual byte", 256'(rxGot[j]), 256'(rdByte(j)));
    rdPre = 1000;
  endtask

  task automatic testSlots();
    for (int w = 0; w < 4; w++) putWord(10, w, ins(1, 3, 2 * w + 2), ins(1, 3, 2 * w + 1));
    putWord(11, 0, ins(1, 0, 8'hFF), ins(1, 0, 8'hFF));
    runSeq(10, 32'h0, 0);
    check("R2", "eight slot order", txBits, 256'h0102030405060708);
    check("R10", "eight slot beats", 256'(beats), 256'(8));
    putWord(12, 0, ins(0, 0, 0), ins(1, 0, 8'hAB));
    putWord(12, 1, ins(1, 0, 8'hCD), ins(1, 0, 8'hCD));
    runSeq(12, 32'h0, 0);
    check("R10", "stop early bits", txBits, 256'hAB);
    check("R10", "stop early beats", 256'(beats), 256'(8));
  endtask

  task automatic testErrors();
    putWord(13, 0, ins(6'h21, 0, 8'h11), ins(1, 0, 8'h05));
    runSeq(13, 32'h0, 0);
    check("R11", "bad opcode err", 256'(err), 256'(1));
    check("R11", "bad opcode beats", 256'(beats), 256'(8));
    repeat (10) @(negedge clk);
    check("R11", "err sticky", 256'(err), 256'(1));
    runSeq(3, 32'h0, 0);
    check("R11", "err cleared by start", 256'(errAfterStart), 256'(0));
    check("R12", "busy after start", 256'(beats), 256'(8));
    putWord(14, 0, ins(2, 0, 12), ins(1, 0, 8'h06));
    runSeq(14, 32'h0, 0);
    check("R11", "bad addr operand err", 256'(err), 256'(1));
    check("R11", "bad addr operand bits", txBits, 256'h06);
    putWord(15, 0, ins(12, 0, 70), ins(1, 0, 8'h07));
    runSeq(15, 32'h0, 0);
    check("R11", "long dummy err", 256'(err), 256'(1));
    check("R6", "long dummy no beats", 256'(beats), 256'(8));
  endtask

  initial begin
    txN = 0; txIdx = 0; devBeat = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCmd();
    testWriteQuad();
    testReadOctal();
    testSlots();
    testErrors();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule